// File: doc/BRIEF.md
# Front-End Readout Queue Occupancy Emulator

This block predicts how full the readout buffer of a remote front-end chip is. That buffer cannot be observed directly. The block sees the same trigger stream the chip receives. Each trigger it accepts reserves a fixed number of buffer slots. The oldest stored event begins its readout once the chip's trigger latency has passed. Its slots are then released after a fixed number of readout clocks. Events leave strictly in the order they arrived.

From the predicted occupancy the block drives a busy flag toward the central trigger system. That system then holds off any trigger the chip would lose. A trigger that arrives while busy is high is dropped and latches a sticky overflow flag. A running trigger number counts the accepted triggers.

A synchronous reset clears the occupancy, the stored events, the trigger number and the overflow flag. While reset is held, the reset also captures the slots-per-trigger setting.

Top module: `readout_queue_emu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `occupancy`, `trig_num`, `busy` and `overflow` are all 0.
- R2: A trigger accepted at a clock edge raises `occupancy` after that edge by the slot size and raises `trig_num` by one. The slot size is 3 when `cfg_triple` was 1 during reset and 1 when it was 0.
- R3: Take an event accepted at edge a, with no earlier event still pending. Its slots are released at edge a + LATENCY + READOUT_CLKS.
- R4: Events are released in arrival order. If the previous event was released at edge d, the next one starts its readout no earlier than edge d+1. Its release edge is therefore max(a + LATENCY, d + 1) + READOUT_CLKS.
- R5: `busy` is high exactly while DEPTH − `occupancy` is less than the slot size. It falls in the same cycle that `occupancy` drops far enough.
- R6: A trigger seen while `busy` is high changes neither `occupancy` nor `trig_num`. It sets `overflow`, which stays at 1 until the next reset.
- R7: `occupancy` stays within 0 to DEPTH. A trigger accepted at the same edge as a release leaves `occupancy` unchanged.
- R8: Changing `cfg_triple` while `rst` is low has no effect on the slot size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Trigger toward the front-end chip, one cycle per trigger |
| cfg_triple | input | 1 | Slot size select, captured while rst is high (1: three slots, 0: one) |
| busy | output | 1 | High while another trigger would not fit |
| occupancy | output | $clog2(DEPTH+1) (6) | Predicted number of occupied buffer slots |
| trig_num | output | TRIG_W (16) | Count of accepted triggers since reset |
| overflow | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
Two cases are hard to reach from the ports. The first is a trigger that lands on the very edge where the oldest event is released. The bench gets there by accepting one event right after reset and placing a second trigger exactly LATENCY + READOUT_CLKS edges later; it then expects no net change in occupancy. The second is the queue held at its limit while it drains. The bench gets there with dense trigger bursts, so that busy falls on a release and rises again on the next accepted trigger. A cycle-level model in the bench, built from release-time arithmetic, predicts every output in every cycle.

// File: rtl/readout_queue_emu_pkg.sv
package readout_queue_emu_pkg;

    localparam int TRIG_W_DEFAULT = 16;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_READ
    } seq_state_e;

    typedef struct packed {
        logic accept;
        logic release_evt;
    } slot_event_t;

    function automatic int slots_per_event(input logic triple);
        return triple ? 3 : 1;
    endfunction

endpackage

// File: rtl/evt_time_fifo.sv
module evt_time_fifo #(
    parameter int DEPTH = 32,
    parameter int TS_W  = 10,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [TS_W-1:0] din,
    output logic [TS_W-1:0] head,
    output logic            nonempty
);

    logic [TS_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head     = mem[rd_ptr];
    assign nonempty = (fill != '0);

endmodule

// File: rtl/readout_sequencer.sv
module readout_sequencer
    import readout_queue_emu_pkg::*;
#(
    parameter int LATENCY      = 160,
    parameter int READOUT_CLKS = 32,
    parameter int TS_W         = 12,
    localparam int RC_W = $clog2(READOUT_CLKS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] head_ts,
    input  logic            has_event,
    output logic            release_evt
);

    seq_state_e      state;
    logic [RC_W-1:0] rd_cnt;
    logic [TS_W-1:0] elapsed;
    logic            head_ready;
    logic            last_clk;

    assign elapsed    = now - head_ts;
    assign head_ready = has_event && (elapsed >= TS_W'(LATENCY));
    assign last_clk   = (rd_cnt == RC_W'(READOUT_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            rd_cnt <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    rd_cnt <= '0;
                    if (head_ready) state <= SEQ_READ;
                end
                SEQ_READ: begin
                    if (last_clk) begin
                        state  <= SEQ_IDLE;
                        rd_cnt <= '0;
                    end else begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign release_evt = (state == SEQ_READ) && last_clk;

endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
    import readout_queue_emu_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             release_evt,
    input  logic [OCC_W-1:0] slots,
    output logic [OCC_W-1:0] occupancy,
    output logic             busy,
    output logic             overflow,
    output slot_event_t      ev
);

    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] add_amt;
    logic [OCC_W-1:0] sub_amt;
    logic             ovf_q;

    assign busy       = (OCC_W'(DEPTH) - occ_q) < slots;
    assign ev.accept      = trig && !busy;
    assign ev.release_evt = release_evt;
    assign add_amt    = ev.accept      ? slots : '0;
    assign sub_amt    = ev.release_evt ? slots : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            occ_q <= occ_q + add_amt - sub_amt;
            if (trig && busy) ovf_q <= 1'b1;
        end
    end

    assign occupancy = occ_q;
    assign overflow  = ovf_q;

endmodule

// File: rtl/readout_queue_emu.sv
module readout_queue_emu
    import readout_queue_emu_pkg::*;
#(
    parameter int DEPTH        = 32,
    parameter int LATENCY      = 160,
    parameter int READOUT_CLKS = 32,
    parameter int TRIG_W       = TRIG_W_DEFAULT,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              cfg_triple,
    output logic              busy,
    output logic [OCC_W-1:0]  occupancy,
    output logic [TRIG_W-1:0] trig_num,
    output logic              overflow
);

    // longest wait an event can see, with one spare bit against wrap
    localparam int MAX_WAIT = LATENCY + DEPTH * (READOUT_CLKS + 1) + 1;
    localparam int TS_W     = $clog2(MAX_WAIT) + 1;

    logic [TS_W-1:0]   now;
    logic [TS_W-1:0]   head_ts;
    logic              has_event;
    logic              release_evt;
    logic [OCC_W-1:0]  slots_q;
    logic [TRIG_W-1:0] trig_cnt;
    slot_event_t       ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            now     <= '0;
            slots_q <= OCC_W'(slots_per_event(cfg_triple));
        end else begin
            now <= now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_cnt <= '0;
        end else if (ev.accept) begin
            trig_cnt <= trig_cnt + 1'b1;
        end
    end

    slot_tracker #(
        .DEPTH(DEPTH)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .release_evt(release_evt),
        .slots      (slots_q),
        .occupancy  (occupancy),
        .busy       (busy),
        .overflow   (overflow),
        .ev         (ev)
    );

    evt_time_fifo #(
        .DEPTH(DEPTH),
        .TS_W (TS_W)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (ev.accept),
        .pop     (ev.release_evt),
        .din     (now),
        .head    (head_ts),
        .nonempty(has_event)
    );

    readout_sequencer #(
        .LATENCY     (LATENCY),
        .READOUT_CLKS(READOUT_CLKS),
        .TS_W        (TS_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .now        (now),
        .head_ts    (head_ts),
        .has_event  (has_event),
        .release_evt(release_evt)
    );

    assign trig_num = trig_cnt;

endmodule

// File: rtl/readout_queue_emu_chk.sv
module readout_queue_emu_chk #(
    parameter int DEPTH  = 32,
    parameter int TRIG_W = 16,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              trig,
    input logic              busy,
    input logic [OCC_W-1:0]  occupancy,
    input logic [TRIG_W-1:0] trig_num,
    input logic              overflow
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (occupancy == '0 && trig_num == '0 && !overflow));

    // R2
    accept_count_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && !busy) |=> (trig_num == $past(trig_num) + 1'b1));

    // R2
    accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && !busy) |=> (occupancy != '0));

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> ($stable(trig_num) && overflow));

    // R6
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7
    occ_range_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= OCC_W'(DEPTH));

    // R5
    busy_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (occupancy != '0));

endmodule

bind readout_queue_emu readout_queue_emu_chk #(
    .DEPTH (DEPTH),
    .TRIG_W(TRIG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .busy     (busy),
    .occupancy(occupancy),
    .trig_num (trig_num),
    .overflow (overflow)
);

// File: tb/readout_queue_emu_test.sv
module readout_queue_emu_test;

    localparam int DEPTH = 32;
    localparam int LAT   = 160;
    localparam int RCLK  = 32;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int NSEG  = 6;

    // stimulus table: length, trigger period (0 = none), expected overflow and empty at end
    localparam int SEG_LEN  [NSEG] = '{300, 100, 60, 1400, 400, 1400};
    localparam int SEG_PER  [NSEG] = '{300, 40, 1, 0, 7, 0};
    localparam int SEG_OVF  [NSEG] = '{0, 0, 1, 1, 1, 1};
    localparam int SEG_EMPTY[NSEG] = '{0, 0, 0, 1, 0, 1};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig = 1'b0;
    logic             cfg_triple = 1'b0;
    logic             busy;
    logic [OCC_W-1:0] occupancy;
    logic [15:0]      trig_num;
    logic             overflow;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int m_e, m_occ, m_trig, m_ovf, m_slots, m_last;
    int dq[$];

    always #2.5 clk = ~clk;

    readout_queue_emu #(
        .DEPTH(DEPTH), .LATENCY(LAT), .READOUT_CLKS(RCLK), .TRIG_W(16)
    ) uut (
        .clk(clk), .rst(rst), .trig(trig), .cfg_triple(cfg_triple),
        .busy(busy), .occupancy(occupancy), .trig_num(trig_num), .overflow(overflow)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_all();
        check("R3 R4 R7 occupancy", int'(occupancy), m_occ);
        check("R5 busy", int'(busy), (m_occ > DEPTH - m_slots) ? 1 : 0);
        check("R2 trig_num", int'(trig_num), m_trig);
        check("R6 overflow", int'(overflow), m_ovf);
    endtask

    // one cycle: check current outputs, drive trig, advance the model over the next edge
    task automatic step(input logic t);
        int mb, st;
        check_all();
        trig = t;
        mb = (m_occ > DEPTH - m_slots) ? 1 : 0;
        if (dq.size() > 0 && dq[0] == m_e) begin
            void'(dq.pop_front());
            m_occ -= m_slots;
        end
        if (t && mb == 1) m_ovf = 1;
        if (t && mb == 0) begin
            st = (m_e + LAT > m_last + 1) ? m_e + LAT : m_last + 1;
            m_last = st + RCLK;
            dq.push_back(m_last);
            m_occ += m_slots;
            m_trig++;
        end
        @(posedge clk);
        m_e++;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic triple);
        @(negedge clk);
        rst = 1'b1;
        trig = 1'b0;
        cfg_triple = triple;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 occupancy in reset", int'(occupancy), 0);
        check("R1 trig_num in reset", int'(trig_num), 0);
        check("R1 overflow in reset", int'(overflow), 0);
        check("R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        m_e = 0; m_occ = 0; m_trig = 0; m_ovf = 0; m_last = -100000;
        m_slots = triple ? 3 : 1;
        dq.delete();
    endtask

    task automatic run_table(input string cfg_name);
        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < SEG_LEN[s]; c++) begin
                step((SEG_PER[s] > 0) && (c % SEG_PER[s] == 0));
            end
            check({"R6 table overflow ", cfg_name}, int'(overflow), SEG_OVF[s]);
            if (SEG_EMPTY[s] == 1)
                check({"R3 table drained ", cfg_name}, int'(occupancy), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // single-slot configuration through the table
        do_reset(1'b0);
        check("R1 first cycle after reset", int'(occupancy) + int'(trig_num) + int'(overflow), 0);
        run_table("single");

        // three-slot configuration, cfg changed afterwards must be ignored (R8)
        do_reset(1'b1);
        cfg_triple = 1'b0;
        step(1'b1);
        check("R8 cfg ignored after reset", int'(occupancy), 3);
        step(1'b0);
        run_table("triple");

        // R3 exact release edge and R7 same-edge trigger and release
        do_reset(1'b0);
        step(1'b1);                                // accepted at edge 0
        for (int i = 1; i < LAT + RCLK; i++) step(1'b0);
        check("R3 still held one edge before release", int'(occupancy), 1);
        step(1'b1);                                // edge LAT+RCLK: release and accept
        check("R7 same-edge trigger and release", int'(occupancy), 1);
        check("R2 trig_num after same-edge", int'(trig_num), 2);

        // R5 busy falls on the release edge when full
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) step(1'b1);
        check("R5 busy when full", int'(busy), 1);
        step(1'b1);
        check("R6 overflow on drop", int'(overflow), 1);
        check("R6 trig_num unchanged by drop", int'(trig_num), DEPTH);
        while (m_occ == DEPTH) step(1'b0);
        check("R5 busy released with slot", int'(busy), 0);
        check("R4 one released", int'(occupancy), DEPTH - 1);
        for (int i = 0; i < 2 * (RCLK + 1); i++) step(1'b0);
        check("R4 ordered release spacing", int'(occupancy), DEPTH - 3);
        check("R6 overflow still sticky", int'(overflow), 1);
        step(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule